// File: doc/BRIEF.md
# Grouped External Interrupt Trigger Unit

This block merges six external interrupt request lines into a single request for the interrupt controller. Each line first passes through a synchroniser. The six synchronised lines are then reduced in two ways. In level mode the request stays high while any line is held low. In edge mode a latched flag sets when the OR of the six lines goes from low to high, and the request follows that flag. The flag clears when the controller signals entry to the service routine with a one-cycle acknowledge pulse.

A single byte-wide control register on a simple register bus holds the trigger-mode select, the read-only edge flag and an unrelated serial-port enable. The serial-port enable is only passed out on a pin. Software selects the mode and polls the flag. The interrupt controller consumes `irq_req` and returns `isr_ack`.

Top module: `eirq_group`

## Requirements
- R1: After reset the control register reads 0x00, `uart_en` is 0, the block is in level mode, and `irq_req` is 0 while all six lines are high.
- R2: Each line passes through two flip-flops. A level change on the pins reaches `irq_req` after the second rising clock edge, and not after the first.
- R3: In level mode (register bit 0 = 0), `irq_req` is 1 exactly when the bitwise AND of the six synchronised lines is 0.
- R4: In edge mode (bit 0 = 1), a change of the OR of the synchronised lines from 0 to 1 sets the edge flag (register bit 1) one cycle later. `irq_req` then equals the flag.
- R5: In edge mode, no other change of the lines sets the flag. This covers falling edges, and changes among the lines while the OR stays at 1.
- R6: An `isr_ack` pulse clears the flag on the next clock edge.
- R7: When a rising edge of the OR and `isr_ack` fall in the same cycle, the flag is set.
- R8: Writing bit 0 = 0 while in edge mode clears a pending flag on the same edge that changes the mode. In level mode the flag always reads 0.
- R9: The previous-OR value is tracked in both modes. Entering edge mode while the OR is already 1 does not set the flag.
- R10: The register sits at address 0x95. Bit 0 is the mode and bit 2 drives `uart_en`; both are writable. Write data on bit 1 is ignored, and writes to any other address change nothing.
- R11: While `bus_rd` is high and the address is 0x95, `bus_rdata` shows the register in the same cycle, with bits 7:3 always 0. Otherwise `bus_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins | input | 6 | Request lines; bit 0 is the lowest-numbered line of the group |
| bus_addr | input | 8 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| isr_ack | input | 1 | Service-routine entry pulse from the interrupt controller |
| irq_req | output | 1 | Shared interrupt request |
| uart_en | output | 1 | Serial-port enable bit of the register |

## Verification
Two events can fall in the same cycle: the flag set from a detected rising edge and the clear from the acknowledge. A second such pair is the flag set and a register write that leaves edge mode. The bench provokes the first pair by timing `isr_ack` so that it is high in exactly the cycle after the second synchroniser edge, which is when the rise is seen. The flag must then read 1. A plain acknowledge one cycle later must read 0. The mode-exit case is judged by reading the register on the cycle after the write: the flag must read 0 and `irq_req` must follow the level rule.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    localparam int unsigned LINES       = 6;
    localparam int unsigned SYNC_DEPTH  = 2;
    localparam int unsigned BUS_W       = 8;
    localparam logic [BUS_W-1:0] CTRL_ADDR = 8'h95;

    // bit positions inside the control byte
    localparam int unsigned BIT_MODE = 0;
    localparam int unsigned BIT_FLAG = 1;
    localparam int unsigned BIT_UART = 2;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_mode_e;

    typedef struct packed {
        trig_mode_e mode;
        logic       uart;
    } ctrl_state_t;

    typedef struct packed {
        logic or_prev;
        logic flag;
    } det_state_t;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int unsigned WIDTH  = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam logic [WIDTH-1:0] IDLE = {WIDTH{1'b1}};

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= IDLE;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
    import eirq_pkg::*;
#(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lines,
    input  trig_mode_e       mode,
    input  logic             mode_drop,
    input  logic             ack,
    output logic             all_high,
    output logic             or_rise,
    output logic             flag
);
    det_state_t st_d, st_q;
    logic       any_high;

    always_comb begin
        any_high = |lines;
        all_high = &lines;
        or_rise  = any_high & ~st_q.or_prev;

        st_d         = st_q;
        st_d.or_prev = any_high;          // tracked in every mode
        if (mode_drop || mode == TRIG_LEVEL) begin
            st_d.flag = 1'b0;
        end else if (or_rise) begin
            st_d.flag = 1'b1;             // set beats acknowledge
        end else if (ack) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{or_prev: 1'b1, flag: 1'b0};
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
    import eirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] addr,
    input  logic [BUS_W-1:0] wdata,
    input  logic             wr,
    input  logic             rd,
    input  logic             flag,
    output logic [BUS_W-1:0] rdata,
    output trig_mode_e       mode,
    output logic             mode_drop,
    output logic             uart
);
    ctrl_state_t st_d, st_q;
    logic        hit_wr, hit_rd;
    logic [BUS_W-1:0] image;

    always_comb begin
        hit_wr = wr && (addr == CTRL_ADDR);
        hit_rd = rd && (addr == CTRL_ADDR);

        st_d = st_q;
        if (hit_wr) begin
            st_d.mode = trig_mode_e'(wdata[BIT_MODE]);
            st_d.uart = wdata[BIT_UART];
        end
        mode_drop = hit_wr && (st_q.mode == TRIG_EDGE) && !wdata[BIT_MODE];

        image           = '0;
        image[BIT_MODE] = st_q.mode;
        image[BIT_FLAG] = flag && (st_q.mode == TRIG_EDGE);
        image[BIT_UART] = st_q.uart;
        rdata           = hit_rd ? image : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: TRIG_LEVEL, uart: 1'b0};
        else        st_q <= st_d;
    end

    assign mode = st_q.mode;
    assign uart = st_q.uart;
endmodule

// File: rtl/eirq_group.sv
module eirq_group
    import eirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_pins,
    input  logic [BUS_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             bus_wr,
    input  logic             bus_rd,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             isr_ack,
    output logic             irq_req,
    output logic             uart_en
);
    logic [LINES-1:0] sync_lines;
    trig_mode_e       ctl_mode;
    logic             mode_drop;
    logic             all_high;
    logic             or_rise;
    logic             edge_flag;

    eirq_sync #(.WIDTH(LINES), .STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_pins),
        .sync_out (sync_lines)
    );

    eirq_detect #(.WIDTH(LINES)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines     (sync_lines),
        .mode      (ctl_mode),
        .mode_drop (mode_drop),
        .ack       (isr_ack),
        .all_high  (all_high),
        .or_rise   (or_rise),
        .flag      (edge_flag)
    );

    eirq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .flag      (edge_flag),
        .rdata     (bus_rdata),
        .mode      (ctl_mode),
        .mode_drop (mode_drop),
        .uart      (uart_en)
    );

    always_comb begin
        irq_req = (ctl_mode == TRIG_EDGE) ? edge_flag : ~all_high;
    end
endmodule

// File: rtl/eirq_group_chk.sv
module eirq_group_chk
    import eirq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] irq_pins,
    input logic [BUS_W-1:0] bus_rdata,
    input logic             isr_ack,
    input logic             irq_req,
    input logic             ctl_mode,
    input logic             mode_drop,
    input logic             or_rise,
    input logic             edge_flag
);
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
    logic settled;
    assign settled = (age_q == 2'd3);

    generate
        if (SYNC_DEPTH == 2) begin : g_lvl
            // R3
            level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                settled && !ctl_mode && !$past(ctl_mode) |-> irq_req == !(&$past(irq_pins, 2)));
        end
    endgenerate

    // R7
    set_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_mode && or_rise && isr_ack && !mode_drop |=> edge_flag);

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr_ack && !or_rise |=> !edge_flag);

    // R8
    level_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_mode |-> !edge_flag);

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7:3] == 5'd0);

    // R4
    edge_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_mode |-> irq_req == edge_flag);
endmodule

bind eirq_group eirq_group_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_pins  (irq_pins),
    .bus_rdata (bus_rdata),
    .isr_ack   (isr_ack),
    .irq_req   (irq_req),
    .ctl_mode  (ctl_mode),
    .mode_drop (mode_drop),
    .or_rise   (or_rise),
    .edge_flag (edge_flag)
);

// File: tb/tb_eirq_group.sv
`timescale 1ns/1ps
module tb_eirq_group;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] irq_pins = 6'h3F;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, isr_ack = 1'b0;
    logic       irq_req, uart_en;
    int         n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    eirq_group dut (.*);

    function automatic logic exp_level(input logic [5:0] p);
        return ~(&p);
    endfunction

    function automatic logic exp_rise(input logic [5:0] prev, input logic [5:0] cur);
        return (|cur) && !(|prev);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cyc(1);
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic pulse_ack();
        isr_ack = 1'b1;
        cyc(1);
        isr_ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h1, 8'h0);
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        logic [5:0] prev, cur;
        logic       exp_flag;
        int unsigned seed;
        seed = $urandom(32'h5EED_0095);

        cyc(3);
        rst_n = 1'b1;
        cyc(3);
        // R1 reset state
        reg_rd(8'h95, rd); chk("R1 reg", rd, 8'h00);
        chk("R1 uart_en", {7'd0, uart_en}, 8'h00);
        chk("R1 irq_req", {7'd0, irq_req}, 8'h00);

        // R2 two-edge latency
        irq_pins = 6'h3E;
        cyc(1); chk("R2 after one edge", {7'd0, irq_req}, 8'h00);
        cyc(1); chk("R2 after two edges", {7'd0, irq_req}, 8'h01);
        irq_pins = 6'h3F; cyc(2);
        chk("R3 all high", {7'd0, irq_req}, 8'h00);

        // R3 random level patterns
        for (int i = 0; i < 40; i++) begin
            cur = 6'($urandom);
            if (i % 5 == 0) cur = 6'h3F;
            irq_pins = cur; cyc(2);
            chk("R3 level", {7'd0, irq_req}, {7'd0, exp_level(cur)});
            reg_rd(8'h95, rd); chk("R8 flag zero in level", rd & 8'h02, 8'h00);
        end

        // enter edge mode with lines idle low
        irq_pins = 6'h00; cyc(3);
        reg_wr(8'h95, 8'h01);
        cyc(1);
        chk("R9 no flag on entry", {7'd0, irq_req}, 8'h00);
        prev = 6'h00; exp_flag = 1'b0;

        // R4/R5/R6 random edge patterns
        for (int i = 0; i < 60; i++) begin
            cur = ($urandom % 2) ? 6'h00 : 6'($urandom);
            irq_pins = cur; cyc(3);
            if (exp_rise(prev, cur)) exp_flag = 1'b1;
            chk(exp_rise(prev, cur) ? "R4 rise sets" : "R5 no set",
                {7'd0, irq_req}, {7'd0, exp_flag});
            reg_rd(8'h95, rd);
            chk("R4 flag bit", rd, {6'd0, exp_flag, 1'b1});
            if ($urandom % 3 == 0) begin
                pulse_ack(); exp_flag = 1'b0;
                chk("R6 ack clears", {7'd0, irq_req}, 8'h00);
            end
            prev = cur;
        end

        // R7 collision of rise and ack
        irq_pins = 6'h00; cyc(3); pulse_ack();
        irq_pins = 6'h10;
        cyc(2);                 // rise is now visible to the detector
        isr_ack = 1'b1; cyc(1); isr_ack = 1'b0;
        chk("R7 set wins", {7'd0, irq_req}, 8'h01);
        pulse_ack();
        chk("R6 plain ack", {7'd0, irq_req}, 8'h00);

        // R8 leaving edge mode clears the flag
        irq_pins = 6'h00; cyc(3);
        irq_pins = 6'h3F; cyc(3);
        chk("R4 flag before exit", {7'd0, irq_req}, 8'h01);
        reg_wr(8'h95, 8'h00);
        reg_rd(8'h95, rd); chk("R8 cleared on exit", rd, 8'h00);
        chk("R8 level rule", {7'd0, irq_req}, 8'h00);

        // R9 re-enter with OR already high
        irq_pins = 6'h21; cyc(3);
        reg_wr(8'h95, 8'h01); cyc(3);
        chk("R9 no false edge", {7'd0, irq_req}, 8'h00);

        // R10 register fields
        reg_wr(8'h95, 8'hFF);
        reg_rd(8'h95, rd); chk("R10 write FF", rd, 8'h05);
        chk("R10 uart_en", {7'd0, uart_en}, 8'h01);
        reg_wr(8'h94, 8'h00);
        reg_rd(8'h95, rd); chk("R10 other address", rd, 8'h05);
        reg_wr(8'h95, 8'h02);
        reg_rd(8'h95, rd); chk("R10 flag not writable", rd, 8'h00);
        chk("R10 uart off", {7'd0, uart_en}, 8'h00);

        // R11 read gating
        reg_wr(8'h95, 8'h04);
        reg_rd(8'h96, rd); chk("R11 wrong address", rd, 8'h00);
        bus_addr = 8'h95; #1;
        chk("R11 no strobe", bus_rdata, 8'h00);
        reg_rd(8'h95, rd); chk("R11 same cycle", rd, 8'h04);

        finish_run();
    end
endmodule